// File: doc/BRIEF.md
# Multitrack Sector Transfer Sequencer

This block runs a multi-sector read or write for a disk-style controller. A single command gives the cylinder, head, first sector, end-of-track sector, a size code, a short data length and three option flags. The sequencer then walks through the sector addresses and counts the bytes of each sector. It moves each byte across to the host through one of two paths: a request/acknowledge handshake meant for a DMA engine, or one interrupt per byte for programmed transfers. A media-side byte-valid input stands in for the disk data path.

With the two-head option set, the two surfaces of a cylinder behave as one long track. When the last sector under head 0 is done, the transfer goes on to sector 1 of head 1 without a new command. When the transfer is finished the block either offers four result bytes to the host or returns directly to idle.

Top module: `mtrk_xfer_seq`

## Requirements
- R1: When idle, a high `cmd_valid` is accepted at the clock edge. From the next cycle `busy` is high and `cur_head`/`cur_sect` show the start head and sector.
- R2: For a size code from 1 to 7, each sector is 128 shifted left by the code in bytes. Code 7 gives 16384 bytes.
- R3: For size code 0, each sector is `cmd_dlen` bytes. A data length of 0 means 128 bytes.
- R4: A size code above 7 is rejected. No byte request is raised, and bit 0 of the status result byte is 1. With a valid code the status byte is 0x00.
- R5: With `cmd_pio`=0, `dma_req` follows `media_vld` during the transfer. A byte completes on `dma_req && dma_ack`, and `irq` stays low.
- R6: With `cmd_pio`=1, `irq` follows `media_vld` during the transfer. A byte completes on `irq && pio_ack`, and `dma_req` stays low.
- R7: `cur_sect` changes only when the last byte of a sector completes. It then goes up by one, unless it already equals the end-of-track sector.
- R8: With `cmd_multi`=0, the transfer ends after the end-of-track sector on the starting head, and the head does not change.
- R9: With `cmd_multi`=1 and start head 0, finishing the end-of-track sector moves the transfer to head 1, sector 1. It ends after the end-of-track sector under head 1. When the head changes during a transfer, `cur_sect` is 1.
- R10: With `cmd_nores`=0, after the transfer `res_valid` offers four bytes in order: status, cylinder, head (bit 0), final sector. Each byte is held until `res_ack`, and the block goes idle after the fourth byte.
- R11: With `cmd_nores`=1, no result byte is offered, and `busy` falls in the cycle after the last byte completes.
- R12: `busy` is high from acceptance until the last result byte is taken. Requests and `res_valid` occur only while busy. `cmd_valid` is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start command strobe |
| cmd_cyl | input | 8 | Cylinder number |
| cmd_head | input | 1 | Start head |
| cmd_sect | input | 8 | Start sector |
| cmd_eot | input | 8 | End-of-track sector |
| cmd_size | input | 8 | Sector size code |
| cmd_dlen | input | 8 | Byte count used with size code 0 |
| cmd_multi | input | 1 | Treat both heads as one track |
| cmd_pio | input | 1 | Per-byte interrupt instead of DMA handshake |
| cmd_nores | input | 1 | Skip the result phase |
| media_vld | input | 1 | Media side has a byte ready |
| dma_req | output | 1 | DMA byte request |
| dma_ack | input | 1 | DMA byte acknowledge |
| irq | output | 1 | Per-byte host interrupt |
| pio_ack | input | 1 | Host served the interrupt byte |
| res_valid | output | 1 | Result byte available |
| res_data | output | 8 | Result byte |
| res_ack | input | 1 | Host took the result byte |
| busy | output | 1 | Command in progress |
| cur_head | output | 1 | Current head |
| cur_sect | output | 8 | Current sector |

## Verification
Some properties are checked on every cycle: the two request paths are never active together, no request or result appears outside busy, a result byte is held until it is taken, the sector number moves only when a byte completes, and a head change mid-transfer lands on sector 1. Other behaviour can only be shown by the bench's scenarios: the byte totals produced by each size code (including the zero-length case and the 16 KiB case), the number of sectors covered with and without the two-head option, the content of the result bytes, a rejected size code, and a command pulse that arrives mid-transfer and is ignored.

// File: rtl/mtrk_pkg.sv
package mtrk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RES  = 2'd2
  } seq_state_t;

  localparam int RES_BYTES = 4;
  localparam int RES_IDX_W = $clog2(RES_BYTES);
endpackage

// File: rtl/mtrk_len.sv
module mtrk_len #(
  parameter int DW   = 8,
  parameter int NMAX = 7,
  parameter int LW   = 8 + NMAX
) (
  input  logic [7:0]    size,
  input  logic [DW-1:0] dlen,
  output logic [LW-1:0] len,
  output logic          bad
);
  localparam logic [LW-1:0] BASE = LW'(128);

  always_comb begin
    bad = (size > 8'(NMAX));
    if (size == 8'd0) begin
      len = (dlen == '0) ? BASE : LW'(dlen);
    end else begin
      len = BASE << size;
    end
  end
endmodule

// File: rtl/mtrk_step.sv
module mtrk_step #(
  parameter int SW = 8,
  parameter int LW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ld_head,
  input  logic [SW-1:0] ld_sect,
  input  logic [SW-1:0] eot,
  input  logic          multi,
  input  logic [LW-1:0] len,
  input  logic          adv,
  output logic          head,
  output logic [SW-1:0] sect,
  output logic          last
);
  logic          head_q, head_d;
  logic [SW-1:0] sect_q, sect_d;
  logic [LW-1:0] bcnt_q, bcnt_d;
  logic          sect_end, at_eot, roll, en;

  always_comb begin
    sect_end = (bcnt_q == len - LW'(1));
    at_eot   = (sect_q == eot);
    roll     = multi && !head_q;
    last     = sect_end && at_eot && !roll;
    en       = load || adv;
    head_d   = head_q;
    sect_d   = sect_q;
    bcnt_d   = bcnt_q;
    if (load) begin
      head_d = ld_head;
      sect_d = ld_sect;
      bcnt_d = '0;
    end else if (adv) begin
      if (!sect_end) begin
        bcnt_d = bcnt_q + LW'(1);
      end else begin
        bcnt_d = '0;
        if (at_eot && roll) begin
          head_d = 1'b1;
          sect_d = SW'(1);
        end else if (!at_eot) begin
          sect_d = sect_q + SW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= 1'b0;
      sect_q <= '0;
      bcnt_q <= '0;
    end else if (en) begin
      head_q <= head_d;
      sect_q <= sect_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign head = head_q;
  assign sect = sect_q;
endmodule

// File: rtl/mtrk_res.sv
module mtrk_res #(
  parameter int NB = 4,
  parameter int IW = 2
) (
  input  logic [IW-1:0]  idx,
  input  logic [NB*8-1:0] fields,
  output logic [7:0]     data
);
  logic [7:0] slot [NB];

  for (genvar g = 0; g < NB; g++) begin : g_slot
    assign slot[g] = fields[g*8 +: 8];
  end

  always_comb begin
    data = 8'h00;
    for (int i = 0; i < NB; i++) begin
      if (idx == IW'(i)) data = slot[i];
    end
  end
endmodule

// File: rtl/mtrk_xfer_seq.sv
module mtrk_xfer_seq
  import mtrk_pkg::*;
#(
  parameter int CW   = 8,
  parameter int SW   = 8,
  parameter int DW   = 8,
  parameter int NMAX = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [CW-1:0] cmd_cyl,
  input  logic          cmd_head,
  input  logic [SW-1:0] cmd_sect,
  input  logic [SW-1:0] cmd_eot,
  input  logic [7:0]    cmd_size,
  input  logic [DW-1:0] cmd_dlen,
  input  logic          cmd_multi,
  input  logic          cmd_pio,
  input  logic          cmd_nores,
  input  logic          media_vld,
  output logic          dma_req,
  input  logic          dma_ack,
  output logic          irq,
  input  logic          pio_ack,
  output logic          res_valid,
  output logic [7:0]    res_data,
  input  logic          res_ack,
  output logic          busy,
  output logic          cur_head,
  output logic [SW-1:0] cur_sect
);
  localparam int LW = 8 + NMAX;

  seq_state_t           state_q, state_d;
  logic [RES_IDX_W-1:0] rid_q, rid_d;
  logic [CW-1:0]        cyl_q;
  logic [SW-1:0]        eot_q;
  logic [LW-1:0]        len_q, len_c;
  logic                 multi_q, pio_q, nores_q, bad_q, bad_c;
  logic                 accept, byte_done, last_byte, in_xfer;

  mtrk_len #(.DW(DW), .NMAX(NMAX), .LW(LW)) i_len (
    .size (cmd_size),
    .dlen (cmd_dlen),
    .len  (len_c),
    .bad  (bad_c)
  );

  assign accept    = (state_q == ST_IDLE) && cmd_valid;
  assign in_xfer   = (state_q == ST_XFER);
  assign dma_req   = in_xfer && media_vld && !pio_q;
  assign irq       = in_xfer && media_vld && pio_q;
  assign byte_done = (dma_req && dma_ack) || (irq && pio_ack);

  mtrk_step #(.SW(SW), .LW(LW)) i_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .ld_head (cmd_head),
    .ld_sect (cmd_sect),
    .eot     (eot_q),
    .multi   (multi_q),
    .len     (len_q),
    .adv     (byte_done),
    .head    (cur_head),
    .sect    (cur_sect),
    .last    (last_byte)
  );

  always_comb begin
    state_d = state_q;
    rid_d   = rid_q;
    case (state_q)
      ST_IDLE: if (cmd_valid) begin
        rid_d = '0;
        if (bad_c) state_d = cmd_nores ? ST_IDLE : ST_RES;
        else       state_d = ST_XFER;
      end
      ST_XFER: if (byte_done && last_byte) begin
        state_d = nores_q ? ST_IDLE : ST_RES;
      end
      ST_RES: if (res_ack) begin
        if (rid_q == RES_IDX_W'(RES_BYTES - 1)) state_d = ST_IDLE;
        else                                    rid_d   = rid_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rid_q   <= '0;
    end else begin
      state_q <= state_d;
      rid_q   <= rid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyl_q   <= '0;
      eot_q   <= '0;
      len_q   <= LW'(128);
      multi_q <= 1'b0;
      pio_q   <= 1'b0;
      nores_q <= 1'b0;
      bad_q   <= 1'b0;
    end else if (accept) begin
      cyl_q   <= cmd_cyl;
      eot_q   <= cmd_eot;
      len_q   <= len_c;
      multi_q <= cmd_multi;
      pio_q   <= cmd_pio;
      nores_q <= cmd_nores;
      bad_q   <= bad_c;
    end
  end

  mtrk_res #(.NB(RES_BYTES), .IW(RES_IDX_W)) i_res (
    .idx    (rid_q),
    .fields ({8'(cur_sect), {7'd0, cur_head}, 8'(cyl_q), {7'd0, bad_q}}),
    .data   (res_data)
  );

  assign res_valid = (state_q == ST_RES);
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/mtrk_chk.sv
module mtrk_chk #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          dma_req,
  input logic          dma_ack,
  input logic          irq,
  input logic          pio_ack,
  input logic          res_valid,
  input logic          res_ack,
  input logic          cur_head,
  input logic [SW-1:0] cur_sect
);
  a_r5_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && irq));

  a_r12_activity_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req || irq || res_valid) |-> busy);

  a_r10_res_held: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ack) |=> res_valid);

  a_r7_sect_moves_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(dma_req && dma_ack) && !$past(irq && pio_ack))
      |-> $stable(cur_sect));

  a_r9_roll_sector_one: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $rose(cur_head)) |-> (cur_sect == SW'(1)));
endmodule

bind mtrk_xfer_seq mtrk_chk #(.SW(SW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .dma_req   (dma_req),
  .dma_ack   (dma_ack),
  .irq       (irq),
  .pio_ack   (pio_ack),
  .res_valid (res_valid),
  .res_ack   (res_ack),
  .cur_head  (cur_head),
  .cur_sect  (cur_sect)
);

// File: tb/test_mtrk_xfer_seq.sv
module test_mtrk_xfer_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_head, cmd_multi, cmd_pio, cmd_nores;
  logic [7:0] cmd_cyl, cmd_sect, cmd_eot, cmd_size, cmd_dlen;
  logic       media_vld, dma_ack, pio_ack, res_ack;
  logic       dma_req, irq, res_valid, busy, cur_head;
  logic [7:0] res_data, cur_sect;

  int n_chk = 0, n_fail = 0;
  int dma_bytes = 0, irq_bytes = 0, res_seen = 0;
  int cycles = 0;
  logic prev_busy = 1'b0, prev_head = 1'b0;
  logic [7:0] exp_q [$];

  always #2.5 clk = ~clk;

  mtrk_xfer_seq i_mtrk_xfer_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cyl(cmd_cyl),
    .cmd_head(cmd_head), .cmd_sect(cmd_sect), .cmd_eot(cmd_eot),
    .cmd_size(cmd_size), .cmd_dlen(cmd_dlen), .cmd_multi(cmd_multi),
    .cmd_pio(cmd_pio), .cmd_nores(cmd_nores), .media_vld(media_vld),
    .dma_req(dma_req), .dma_ack(dma_ack), .irq(irq), .pio_ack(pio_ack),
    .res_valid(res_valid), .res_data(res_data), .res_ack(res_ack),
    .busy(busy), .cur_head(cur_head), .cur_sect(cur_sect)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // Monitor: byte counting, scoreboard pops, head roll check
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
    if (rst_n) begin
      if (dma_req && dma_ack) dma_bytes++;
      if (irq && pio_ack) irq_bytes++;
      if (res_valid) res_seen++;
      if (res_valid && res_ack) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected result byte", res_data, -1);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          chk(res_data == e, "R10 result byte", res_data, e);
        end
      end
      if (busy && prev_busy && cur_head && !prev_head)
        chk(cur_sect == 8'd1, "R9 sector after head change", cur_sect, 1);
      prev_busy = busy;
      prev_head = cur_head;
    end
  end

  task automatic run(input logic [7:0] cyl, input logic hd, input logic [7:0] st,
                     input logic [7:0] eot, input logic [7:0] sz, input logic [7:0] dl,
                     input logic mt, input logic pio, input logic nr, input bit poke,
                     input string tag);
    int len, nsec, exp_bytes;
    bit bad;
    bad = (sz > 8'd7);
    if (sz == 0) len = (dl == 0) ? 128 : int'(dl);
    else len = 128 << sz;
    nsec = int'(eot) - int'(st) + 1;
    if (mt && !hd) nsec += int'(eot);
    exp_bytes = bad ? 0 : nsec * len;
    dma_bytes = 0; irq_bytes = 0; res_seen = 0;
    if (!nr) begin
      exp_q.push_back(bad ? 8'h01 : 8'h00);
      exp_q.push_back(cyl);
      exp_q.push_back({7'd0, (bad ? hd : (mt | hd))});
      exp_q.push_back(bad ? st : eot);
    end
    cmd_cyl = cyl; cmd_head = hd; cmd_sect = st; cmd_eot = eot; cmd_size = sz;
    cmd_dlen = dl; cmd_multi = mt; cmd_pio = pio; cmd_nores = nr; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, {"R1 busy after accept ", tag}, busy, 1);
    chk(cur_sect == st && cur_head == hd, {"R1 start address ", tag}, cur_sect, st);
    if (poke) begin
      repeat (10) @(negedge clk);
      cmd_cyl = 8'h77; cmd_sect = 8'h09; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == 1'b1, "R12 busy through ignored command", busy, 1);
    end
    while (busy) @(negedge clk);
    chk(dma_bytes + irq_bytes == exp_bytes, {"R2/R3 byte total ", tag},
        dma_bytes + irq_bytes, exp_bytes);
    if (pio) chk(dma_bytes == 0, {"R6 no DMA request ", tag}, dma_bytes, 0);
    else     chk(irq_bytes == 0, {"R5 no interrupt ", tag}, irq_bytes, 0);
    chk(exp_q.size() == 0, {"R10 all results delivered ", tag}, exp_q.size(), 0);
    if (nr) chk(res_seen == 0, {"R11 no result phase ", tag}, res_seen, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_head = 1'b0; cmd_multi = 1'b0;
    cmd_pio = 1'b0; cmd_nores = 1'b0; cmd_cyl = '0; cmd_sect = '0;
    cmd_eot = '0; cmd_size = '0; cmd_dlen = '0;
    media_vld = 1'b1; dma_ack = 1'b1; pio_ack = 1'b1; res_ack = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !dma_req && !irq && !res_valid, "R12 reset state idle", busy, 0);
    // R2 R5 R8 R12: DMA, 256-byte sectors 3..5 on head 0, poke while busy
    run(8'h21, 1'b0, 8'd3, 8'd5, 8'd1, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1, "dma_n1");
    // R3 R6 R9: PIO, 20-byte sectors, two-head roll 1..3
    run(8'h05, 1'b0, 8'd1, 8'd3, 8'd0, 8'd20, 1'b1, 1'b1, 1'b0, 1'b0, "pio_mt");
    // R3: zero length means 128, two-head option on head 1 does not roll
    run(8'h40, 1'b1, 8'd2, 8'd2, 8'd0, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0, "dlen0_h1");
    // R4: size code above 7 rejected
    run(8'h12, 1'b0, 8'd4, 8'd9, 8'd9, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, "bad_size");
    // R11: result phase skipped
    run(8'h33, 1'b0, 8'd1, 8'd1, 8'd2, 8'd0, 1'b0, 1'b1, 1'b1, 1'b0, "nores");
    // R2: largest code, 16384 bytes
    run(8'h01, 1'b0, 8'd7, 8'd7, 8'd7, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, "n7");
    // R7: stall media and check sector holds
    cmd_cyl = 8'h02; cmd_head = 1'b0; cmd_sect = 8'd1; cmd_eot = 8'd2;
    cmd_size = 8'd0; cmd_dlen = 8'd4; cmd_multi = 1'b0; cmd_pio = 1'b0;
    cmd_nores = 1'b1; media_vld = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(cur_sect == 8'd1 && !dma_req, "R7 sector holds without bytes", cur_sect, 1);
    media_vld = 1'b1;
    repeat (4) @(negedge clk);
    chk(cur_sect == 8'd2, "R7 sector advanced after 4 bytes", cur_sect, 2);
    while (busy) @(negedge clk);
    chk(cur_sect == 8'd2 && !cur_head, "R8 stopped at end of track", cur_sect, 2);
    finish_run();
  end
endmodule